// File: doc/BRIEF.md
# Repeated String Store Sequencer

This block steps a store-string operation. A pulse on `start_i` captures the accumulator value, the starting destination index, the element size, the direction flag, the repeat flag and the starting count. Each iteration writes the accumulator byte or word to the current index over a write port with a ready handshake. It then moves the index by the element size, up or down. When the repeat flag is set, the count is decremented after every store and the loop continues until the count reaches zero. A zero count at entry finishes at once and performs no store.

Pending interrupts are sampled only after a store has completed, never before the first one. Even an interrupt that stays pending all the time therefore lets every entry make one store of progress. On an interrupt the block stops with the advanced index and the decremented count visible on its outputs and pulses `intr_o`. The surrounding core can service the interrupt and start the block again with those values. A normal finish pulses `done_o`.

Top module: `strs_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_valid_o`, `done_o` and `intr_o` are all 0.
- R2: While a store is offered, `mem_addr_o` equals the current index. `mem_word_o` equals the captured size flag. `mem_data_o` is the full accumulator for a word (size flag 1); for a byte (size flag 0) it is the low byte with the high byte zero.
- R3: Each accepted store moves the index by 1 for a byte or 2 for a word. It moves up when the direction flag is 0 and down when it is 1, wrapping modulo 2^16.
- R4: With the repeat flag 0, exactly one store is made, `cnt_o` keeps the loaded count, `irq_pend_i` is ignored and `done_o` pulses.
- R5: With the repeat flag 1 and a zero count at start, no store is made, the index is unchanged and `done_o` pulses in the cycle after the start is taken.
- R6: With the repeat flag 1 and no pending interrupt, exactly as many stores are made as the starting count, and `cnt_o` ends at 0.
- R7: With the repeat flag 1, the pending interrupt is sampled only after a store. If it is set and the decremented count is nonzero, the block stops after that single store and pulses `intr_o`, with `idx_o` and `cnt_o` showing the advanced index and the decremented count.
- R8: When the store that brings the count to zero completes while an interrupt is pending, the block pulses `done_o`, not `intr_o`.
- R9: A store that is not yet accepted keeps `mem_valid_o`, `mem_addr_o` and `mem_data_o` unchanged until `mem_ready_i` is 1.
- R10: `start_i` has no effect while `busy_o` is 1.
- R11: `done_o` and `intr_o` are single-cycle pulses, never high together, and `busy_o` is 0 when either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken when idle) |
| word_i | input | 1 | Element size: 1 word, 0 byte |
| dir_i | input | 1 | Direction: 0 up, 1 down |
| rep_i | input | 1 | Repeat flag |
| acc_i | input | 16 | Accumulator value to store |
| idx_i | input | 16 | Starting destination index |
| cnt_i | input | 16 | Starting count |
| irq_pend_i | input | 1 | Interrupt pending |
| mem_ready_i | input | 1 | Write accepted this cycle |
| mem_valid_o | output | 1 | Write offered |
| mem_addr_o | output | 16 | Write address |
| mem_data_o | output | 16 | Write data |
| mem_word_o | output | 1 | Write size |
| idx_o | output | 16 | Current index |
| cnt_o | output | 16 | Current count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Finished pulse |
| intr_o | output | 1 | Stopped for interrupt pulse |

## Verification
Two decisions meet in the same cycle when the last store of a repeated run completes while an interrupt is pending. The count reaching zero and the interrupt sample then compete. The bench provokes this by re-entering the block with the interrupt held high until the count is 1, and by a direct start with a count of 1. It judges the result by which pulse appears and by the final index and count. A stalled ready that overlaps a stray start, and a non-repeat store with the interrupt held, are also checked.

// File: rtl/strs_pkg.sv
package strs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_STORE = 2'd1,
      ST_CHECK = 2'd2
   } strs_state_e;
endpackage

// File: rtl/strs_idx_unit.sv
module strs_idx_unit #(
   parameter int AW      = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          adv_i,
   input  logic          word_i,
   input  logic          dir_i,
   output logic [AW-1:0] idx_o
);
   logic [AW-1:0] step;
   logic [AW-1:0] idx_q;

   generate
      if (WORD_EN) begin : g_word
         assign step = word_i ? AW'(2) : AW'(1);
      end else begin : g_byte_only
         assign step = AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (load_i) idx_q <= load_val_i;
      else if (adv_i)  idx_q <= dir_i ? (idx_q - step) : (idx_q + step);
   end

   assign idx_o = idx_q;
endmodule

// File: rtl/strs_cnt_unit.sv
module strs_cnt_unit #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          dec_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - CW'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/strs_ctrl.sv
module strs_ctrl
   import strs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rep_i,
   input  logic word_i,
   input  logic dir_i,
   input  logic cnt_in_zero_i,
   input  logic cnt_last_i,
   input  logic irq_i,
   input  logic mem_ready_i,
   output logic load_o,
   output logic store_o,
   output logic adv_o,
   output logic dec_o,
   output logic word_q_o,
   output logic dir_q_o,
   output logic busy_o,
   output logic done_o,
   output logic intr_o
);
   strs_state_e state_q, state_d;
   logic rep_q, word_q, dir_q;
   logic done_d, intr_d, done_q, intr_q;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      store_o = 1'b0;
      adv_o   = 1'b0;
      dec_o   = 1'b0;
      done_d  = 1'b0;
      intr_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o = 1'b1;
               if (rep_i && cnt_in_zero_i) done_d  = 1'b1;
               else                        state_d = ST_STORE;
            end
         end
         ST_STORE: begin
            store_o = 1'b1;
            if (mem_ready_i) begin
               adv_o   = 1'b1;
               state_d = ST_CHECK;
            end
         end
         ST_CHECK: begin
            dec_o = rep_q;
            if (!rep_q || cnt_last_i) begin
               done_d  = 1'b1;
               state_d = ST_IDLE;
            end else if (irq_i) begin
               intr_d  = 1'b1;
               state_d = ST_IDLE;
            end else begin
               state_d = ST_STORE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rep_q   <= 1'b0;
         word_q  <= 1'b0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
         intr_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         intr_q  <= intr_d;
         if (load_o) begin
            rep_q  <= rep_i;
            word_q <= word_i;
            dir_q  <= dir_i;
         end
      end
   end

   assign word_q_o = word_q;
   assign dir_q_o  = dir_q;
   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign intr_o   = intr_q;
endmodule

// File: rtl/strs_seq.sv
module strs_seq #(
   parameter int BW      = 8,
   parameter int AW      = 16,
   parameter int CW      = 16,
   parameter bit WORD_EN = 1'b1,
   localparam int DW     = 2 * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          word_i,
   input  logic          dir_i,
   input  logic          rep_i,
   input  logic [DW-1:0] acc_i,
   input  logic [AW-1:0] idx_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          irq_pend_i,
   input  logic          mem_ready_i,
   output logic          mem_valid_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_data_o,
   output logic          mem_word_o,
   output logic [AW-1:0] idx_o,
   output logic [CW-1:0] cnt_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          intr_o
);
   generate
      if (BW < 1) begin : g_bad_bw
         $error("strs_seq: BW must be at least 1");
      end
      if (AW < 2) begin : g_bad_aw
         $error("strs_seq: AW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("strs_seq: CW must be at least 1");
      end
   endgenerate

   logic          load, adv, dec, cnt_last, word_q, dir_q;
   logic [DW-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (load) acc_q <= acc_i;
   end

   strs_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .rep_i        (rep_i),
      .word_i       (word_i),
      .dir_i        (dir_i),
      .cnt_in_zero_i(cnt_i == '0),
      .cnt_last_i   (cnt_last),
      .irq_i        (irq_pend_i),
      .mem_ready_i  (mem_ready_i),
      .load_o       (load),
      .store_o      (mem_valid_o),
      .adv_o        (adv),
      .dec_o        (dec),
      .word_q_o     (word_q),
      .dir_q_o      (dir_q),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .intr_o       (intr_o)
   );

   strs_idx_unit #(.AW(AW), .WORD_EN(WORD_EN)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .load_val_i(idx_i),
      .adv_i     (adv),
      .word_i    (word_q),
      .dir_i     (dir_q),
      .idx_o     (idx_o)
   );

   strs_cnt_unit #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .load_val_i(cnt_i),
      .dec_i     (dec),
      .cnt_o     (cnt_o),
      .last_o    (cnt_last)
   );

   generate
      if (WORD_EN) begin : g_data_word
         assign mem_word_o = word_q;
         assign mem_data_o = word_q ? acc_q : {{BW{1'b0}}, acc_q[BW-1:0]};
      end else begin : g_data_byte
         assign mem_word_o = 1'b0;
         assign mem_data_o = {{BW{1'b0}}, acc_q[BW-1:0]};
      end
   endgenerate

   assign mem_addr_o = idx_o;
endmodule

// File: rtl/strs_seq_chk.sv
module strs_seq_chk #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_valid_o,
   input logic          mem_ready_i,
   input logic [AW-1:0] mem_addr_o,
   input logic [DW-1:0] mem_data_o,
   input logic [AW-1:0] idx_o,
   input logic [CW-1:0] cnt_o,
   input logic          busy_o,
   input logic          done_o,
   input logic          intr_o
);
   // R1
   valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o |-> busy_o);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && !mem_ready_i) |=>
         (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

   // R3
   index_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && mem_ready_i) |=> (idx_o != $past(idx_o)));

   // R7
   intr_after_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> (cnt_o == CW'($past(cnt_o) - CW'(1))));

   // R11
   pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && intr_o));

   // R11
   end_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || intr_o) |-> !busy_o);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind strs_seq strs_seq_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_valid_o(mem_valid_o),
   .mem_ready_i(mem_ready_i),
   .mem_addr_o (mem_addr_o),
   .mem_data_o (mem_data_o),
   .idx_o      (idx_o),
   .cnt_o      (cnt_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .intr_o     (intr_o)
);

// File: tb/strs_seq_tb.sv
module strs_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, word_i = 1'b0, dir_i = 1'b0, rep_i = 1'b0;
   logic [15:0] acc_i = '0, idx_i = '0, cnt_i = '0;
   logic        irq_pend_i = 1'b0, mem_ready_i = 1'b1;
   logic        mem_valid_o, mem_word_o, busy_o, done_o, intr_o;
   logic [15:0] mem_addr_o, mem_data_o, idx_o, cnt_o;

   int total = 0, bad = 0, stores = 0, cyc = 0;
   bit stall = 1'b0;
   logic [15:0] q_addr[$], q_data[$];
   logic        q_word[$];

   always #4 clk = ~clk;

   strs_seq u_dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   always @(posedge clk) begin
      #2 mem_ready_i = stall ? (cyc[0] ^ cyc[2]) : 1'b1;
   end

   // monitor: scoreboard of stores and stall hold
   logic        prev_wait = 1'b0;
   logic [15:0] prev_addr, prev_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_wait)
            chk(mem_valid_o && mem_addr_o == prev_addr && mem_data_o == prev_data,
                "R9", "held store", mem_addr_o, prev_addr);
         if (mem_valid_o && mem_ready_i) begin
            stores++;
            if (q_addr.size() == 0) begin
               chk(1'b0, "R4", "unexpected store", mem_addr_o, 0);
            end else begin
               logic [15:0] ea, ed;
               logic ew;
               ea = q_addr.pop_front(); ed = q_data.pop_front(); ew = q_word.pop_front();
               chk(mem_addr_o == ea, "R3", "store address", mem_addr_o, ea);
               chk(mem_data_o == ed && mem_word_o == ew, "R2", "store data",
                   {mem_word_o, mem_data_o}, {ew, ed});
            end
         end
         prev_wait = mem_valid_o && !mem_ready_i;
         prev_addr = mem_addr_o;
         prev_data = mem_data_o;
      end
   end

   task automatic run_op(input logic [15:0] idx, input logic [15:0] cnt,
                         input logic [15:0] acc, input bit w, input bit d,
                         input bit r, input bit irq, input bit stray,
                         input string req, output logic [15:0] fidx,
                         output logic [15:0] fcnt);
      int n;
      bit exp_intr;
      logic [15:0] step, eidx, ecnt;
      step = w ? 16'd2 : 16'd1;
      if (r && cnt == 0)  n = 0;
      else if (!r)        n = 1;
      else if (irq)       n = 1;
      else                n = int'(cnt);
      exp_intr = r && irq && cnt > 1;
      for (int k = 0; k < n; k++) begin
         q_addr.push_back(d ? idx - step * 16'(k) : idx + step * 16'(k));
         q_data.push_back(w ? acc : {8'h00, acc[7:0]});
         q_word.push_back(w);
      end
      eidx = d ? idx - step * 16'(n) : idx + step * 16'(n);
      ecnt = r ? cnt - 16'(n) : cnt;
      stores = 0;
      @(posedge clk); #2;
      idx_i = idx; cnt_i = cnt; acc_i = acc; word_i = w; dir_i = d; rep_i = r;
      irq_pend_i = irq; start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      if (stray) begin
         @(posedge clk); #2;
         idx_i = 16'h7777; cnt_i = 16'd9; start_i = 1'b1;
         @(posedge clk); #2;
         start_i = 1'b0;
      end
      @(negedge clk);
      while (!done_o && !intr_o) @(negedge clk);
      chk(intr_o == exp_intr && done_o == !exp_intr, req, "end pulse (R7/R8)",
          {intr_o, done_o}, {exp_intr, !exp_intr});
      chk(idx_o == eidx, req, "final index", idx_o, eidx);
      chk(cnt_o == ecnt, req, "final count", cnt_o, ecnt);
      chk(stores == n && q_addr.size() == 0, req, "store count", stores, n);
      chk(!busy_o, "R11", "idle at end", busy_o, 0);
      fidx = idx_o; fcnt = cnt_o;
      @(negedge clk);
      chk(!done_o && !intr_o, "R11", "single pulse", {done_o, intr_o}, 0);
      irq_pend_i = 1'b0;
   endtask

   initial begin
      logic [15:0] fi, fc;
      int guard;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy_o && !mem_valid_o && !done_o && !intr_o, "R1", "reset state",
          {busy_o, mem_valid_o, done_o, intr_o}, 0);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !mem_valid_o, "R1", "idle after reset", {busy_o, mem_valid_o}, 0);

      // R4 R2: single byte store, upward, count kept
      run_op(16'h0100, 16'd7, 16'hA5C3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4", fi, fc);
      // R4: single word store downward with interrupt held -> ignored
      run_op(16'h0200, 16'd3, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4", fi, fc);
      // R5: repeat with zero count
      run_op(16'h0300, 16'd0, 16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5", fi, fc);
      // R6 R9: repeated words upward, stalled ready
      stall = 1'b1;
      run_op(16'h0400, 16'd5, 16'hCAFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6", fi, fc);
      // R6 R3: repeated bytes downward, stalled
      run_op(16'h0010, 16'd4, 16'h0F5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6", fi, fc);
      stall = 1'b0;
      // R7: interrupt storm; re-enter until the final store finishes (R8)
      fi = 16'h0500; fc = 16'd4; guard = 0;
      while (fc > 1 && guard < 10) begin
         run_op(fi, fc, 16'h7E81, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7", fi, fc);
         guard++;
      end
      chk(fi == 16'h04FD && fc == 16'd1, "R7", "progress under storm", {fi, fc}, {16'h04FD, 16'd1});
      run_op(fi, fc, 16'h7E81, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8", fi, fc);
      // R8: direct last iteration with interrupt pending
      run_op(16'h0600, 16'd1, 16'h4411, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8", fi, fc);
      // R10: stray start while busy, with stalls
      stall = 1'b1;
      run_op(16'h0700, 16'd3, 16'h9999, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10", fi, fc);
      stall = 1'b0;
      // R3: wrap around the top of the index range
      run_op(16'hFFFF, 16'd2, 16'h2468, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3", fi, fc);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule